// File: doc/BRIEF.md
# Serial PHY Power Sequencer

This block walks the control bits of a high-speed serial PHY through its power-up and power-down orderings so that software only has to issue one request per transition. A start request in the idle state pulses the PHY reset for a programmable number of cycles. After the release it picks the reference source: the pad input when an external crystal is present, the internal source otherwise. It then waits a programmable settle time for the reference clock. Last, it raises PHY enable and lane power-present together and reports ready.

A stop request tears the PHY down in a fixed three-step order. Enable goes low first, then the pad reference select, then the power-down (retention) bit is set. After each step the sequencer compares the PHY's echoed control bit against the value it intended and raises a sticky error flag on any mismatch. A stop request also cuts short a power-up that is still running. Delays are parameters counted in clock cycles, so a simulation can shorten them.

Top module: `phy_pwr_seq`

## Requirements
- R1: A synchronous active-high reset drives every control output, ready and error low, sets idle high, and returns the state machine to idle, including when a power-up is in progress.
- R2: A start request accepted in idle raises the PHY reset output one cycle later and holds it for exactly RESET_CYCLES cycles. In the same step it clears power-down, clears the error flag and keeps enable low.
- R3: One cycle after the PHY reset is released, the pad reference select takes the value of the crystal-present input. It then stays constant while the PHY is enabled.
- R4: Exactly SETTLE_CYCLES cycles after the reference selection, PHY enable, lane power-present and ready rise together in the same cycle. Ready is never high without enable.
- R5: idle is high only when no sequence is running: from reset or teardown completion until the next accepted start.
- R6: A start request while the sequencer is not idle is ignored. In particular, ready stays high when start is pulsed in the powered state.
- R7: A stop request during any power-up step or in the powered state takes priority. In the next cycle enable, lane power-present, ready and the PHY reset are all low.
- R8: Teardown order is strict, one cycle per step. Enable falls first, the pad select falls one cycle later, power-down rises one cycle after that, and idle rises one cycle after power-down.
- R9: Echo bit 0 (enable) is checked for 0 one cycle after the enable step, bit 1 (pad select) for 0 after the pad step, and bit 2 (power-down) for 1 after the power-down step. A mismatch sets the error output in the following cycle. The error output stays set until the next accepted start clears it.
- R10: In idle a stop request is ignored, and a start asserted together with stop is also ignored; the outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to power the PHY up |
| stop_req | input | 1 | Request to power the PHY down (priority) |
| xtal_present | input | 1 | External crystal reference available |
| ctl_echo | input | 3 | Readback of PHY control bits: [0] enable, [1] pad select, [2] power-down |
| phy_reset_o | output | 1 | PHY reset control bit |
| ref_pad_sel_o | output | 1 | Take reference clock from the pad |
| phy_en_o | output | 1 | PHY enable |
| lane_pwr_o | output | 1 | Lane 0 power present |
| pwr_down_o | output | 1 | Power-down / retention request |
| ready_o | output | 1 | PHY powered and enabled |
| idle_o | output | 1 | No sequence in progress |
| err_o | output | 1 | Sticky teardown readback mismatch |

## Verification
The properties assume that xtal_present holds steady from an accepted start until enable rises, and that ctl_echo shows the control outputs as they stand after the preceding edge, apart from deliberate faults. Both delay parameters are also assumed to be at least one. The stimulus holds the crystal flag constant for each whole sequence and derives the echo directly from the outputs. Faults are injected only as a fixed per-run inversion of one echo bit. Random start pulses are placed only on cycles where no stop is asserted, and stop points range over every power-up phase.

// File: rtl/phy_pwr_seq_pkg.sv
package phy_pwr_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RST,
        S_REFSEL,
        S_SETTLE,
        S_ON,
        S_TD_EN,
        S_TD_PAD,
        S_TD_PDN
    } seq_state_e;

    // Control word driven towards the PHY
    typedef struct packed {
        logic pdn;
        logic pad;
        logic lane;
        logic en;
        logic rst;
    } ctl_t;

    // Echo bit positions
    localparam int ECHO_W   = 3;
    localparam int ECHO_EN  = 0;
    localparam int ECHO_PAD = 1;
    localparam int ECHO_PDN = 2;

    function automatic logic seq_powering(seq_state_e s);
        return (s == S_RST) || (s == S_REFSEL) || (s == S_SETTLE) || (s == S_ON);
    endfunction

    function automatic logic [ECHO_W-1:0] echo_bit(int idx);
        logic [ECHO_W-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/phy_pwr_seq_timer.sv
module phy_pwr_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == limit - 1'b1);

endmodule

// File: rtl/phy_pwr_seq_rbchk.sv
module phy_pwr_seq_rbchk #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] chk_mask,
    input  logic [W-1:0] chk_expect,
    input  logic [W-1:0] echo,
    output logic         err
);
    logic mismatch;

    assign mismatch = |((echo ^ chk_expect) & chk_mask);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            err <= 1'b0;
        end else if (mismatch) begin
            err <= 1'b1;
        end
    end

    // R9: error flag is sticky until a start clears it
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err && !clr |=> err);

    // R9: one echo bit is checked per teardown step
    p_one_step_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chk_mask));

endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
    import phy_pwr_seq_pkg::*;
#(
    parameter int RESET_CYCLES  = 200,
    parameter int SETTLE_CYCLES = 3000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              xtal_present,
    input  logic [ECHO_W-1:0] ctl_echo,
    output logic              phy_reset_o,
    output logic              ref_pad_sel_o,
    output logic              phy_en_o,
    output logic              lane_pwr_o,
    output logic              pwr_down_o,
    output logic              ready_o,
    output logic              idle_o,
    output logic              err_o
);
    localparam int MAX_CYC = (RESET_CYCLES > SETTLE_CYCLES) ? RESET_CYCLES : SETTLE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    seq_state_e        st;
    ctl_t              ctl;
    logic              rdy;
    logic              accept;
    logic              tmr_clr;
    logic              tmr_done;
    logic [CNT_W-1:0]  tmr_limit;
    logic [ECHO_W-1:0] chk_mask;
    logic [ECHO_W-1:0] chk_expect;

    assign accept    = (st == S_IDLE) && start_req && !stop_req;
    assign tmr_clr   = accept || (st == S_REFSEL);
    assign tmr_limit = (st == S_RST) ? CNT_W'(RESET_CYCLES) : CNT_W'(SETTLE_CYCLES);

    phy_pwr_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (tmr_clr),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_IDLE;
            ctl <= '0;
            rdy <= 1'b0;
        end else if (seq_powering(st) && stop_req) begin
            st       <= S_TD_EN;
            ctl.en   <= 1'b0;
            ctl.lane <= 1'b0;
            ctl.rst  <= 1'b0;
            rdy      <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (accept) begin
                        st      <= S_RST;
                        ctl.rst <= 1'b1;
                        ctl.pdn <= 1'b0;
                    end
                end
                S_RST: begin
                    if (tmr_done) begin
                        ctl.rst <= 1'b0;
                        st      <= S_REFSEL;
                    end
                end
                S_REFSEL: begin
                    ctl.pad <= xtal_present;
                    st      <= S_SETTLE;
                end
                S_SETTLE: begin
                    if (tmr_done) begin
                        ctl.en   <= 1'b1;
                        ctl.lane <= 1'b1;
                        rdy      <= 1'b1;
                        st       <= S_ON;
                    end
                end
                S_ON: begin
                    st <= S_ON;
                end
                S_TD_EN: begin
                    ctl.pad <= 1'b0;
                    st      <= S_TD_PAD;
                end
                S_TD_PAD: begin
                    ctl.pdn <= 1'b1;
                    st      <= S_TD_PDN;
                end
                S_TD_PDN: begin
                    st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Readback step selection during teardown
    always_comb begin
        chk_mask   = '0;
        chk_expect = '0;
        unique case (st)
            S_TD_EN:  chk_mask = echo_bit(ECHO_EN);
            S_TD_PAD: chk_mask = echo_bit(ECHO_PAD);
            S_TD_PDN: begin
                chk_mask   = echo_bit(ECHO_PDN);
                chk_expect = echo_bit(ECHO_PDN);
            end
            default: chk_mask = '0;
        endcase
    end

    phy_pwr_seq_rbchk #(.W(ECHO_W)) u_rbchk (
        .clk        (clk),
        .rst        (rst),
        .clr        (accept),
        .chk_mask   (chk_mask),
        .chk_expect (chk_expect),
        .echo       (ctl_echo),
        .err        (err_o)
    );

    assign phy_reset_o   = ctl.rst;
    assign ref_pad_sel_o = ctl.pad;
    assign phy_en_o      = ctl.en;
    assign lane_pwr_o    = ctl.lane;
    assign pwr_down_o    = ctl.pdn;
    assign ready_o       = rdy;
    assign idle_o        = (st == S_IDLE);

    // R4: ready implies the PHY is enabled and its lane powered
    p_ready_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> phy_en_o && lane_pwr_o);

    // R2: reset pulse never overlaps enable or power-down
    p_reset_excl_en_r2: assert property (@(posedge clk) disable iff (rst)
        phy_reset_o |-> !phy_en_o && !pwr_down_o);

    // R3: reference select is frozen while enabled
    p_pad_held_r3: assert property (@(posedge clk) disable iff (rst)
        phy_en_o |=> !phy_en_o || $stable(ref_pad_sel_o));

    // R7: stop during power-up or powered state tears down at once
    p_stop_tears_r7: assert property (@(posedge clk) disable iff (rst)
        seq_powering(st) && stop_req |=> !phy_en_o && !ready_o && !phy_reset_o);

    // R8: power-down only rises after enable and pad select are low
    p_pdn_after_pad_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_down_o) |-> !ref_pad_sel_o && !phy_en_o);

    // R6: a start pulse in the powered state changes nothing
    p_start_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        ready_o && start_req && !stop_req |=> ready_o);

    // R10: idle holds unless a start is accepted
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        idle_o && !(start_req && !stop_req) |=> idle_o && !phy_en_o);

endmodule

// File: tb/sim_phy_pwr_seq.sv
module sim_phy_pwr_seq;

    localparam int RC = 5;
    localparam int SC = 9;
    localparam int WATCHDOG_CYC = 150000;

    // expected output vector: {rst, pad, en, lane, pdn, ready, idle, err}
    typedef struct packed {
        logic rst;
        logic pad;
        logic en;
        logic lane;
        logic pdn;
        logic ready;
        logic idle;
        logic err;
    } obs_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_req = 1'b0;
    logic       stop_req = 1'b0;
    logic       xtal_present = 1'b0;
    logic [2:0] fault = 3'b000;
    logic [2:0] ctl_echo;
    logic phy_reset_o, ref_pad_sel_o, phy_en_o, lane_pwr_o, pwr_down_o;
    logic ready_o, idle_o, err_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign ctl_echo = {pwr_down_o, ref_pad_sel_o, phy_en_o} ^ fault;

    phy_pwr_seq #(.RESET_CYCLES(RC), .SETTLE_CYCLES(SC)) u0 (
        .clk           (clk),
        .rst           (rst),
        .start_req     (start_req),
        .stop_req      (stop_req),
        .xtal_present  (xtal_present),
        .ctl_echo      (ctl_echo),
        .phy_reset_o   (phy_reset_o),
        .ref_pad_sel_o (ref_pad_sel_o),
        .phy_en_o      (phy_en_o),
        .lane_pwr_o    (lane_pwr_o),
        .pwr_down_o    (pwr_down_o),
        .ready_o       (ready_o),
        .idle_o        (idle_o),
        .err_o         (err_o)
    );

    function automatic obs_t observe();
        return {phy_reset_o, ref_pad_sel_o, phy_en_o, lane_pwr_o,
                pwr_down_o, ready_o, idle_o, err_o};
    endfunction

    // Expected outputs c cycles after the start edge, stop sampled at edge k
    function automatic obs_t expect_at(int c, int k, bit x, logic [2:0] f);
        obs_t e;
        int d;
        e = '0;
        if (c <= k) begin
            e.rst   = (c >= 1) && (c <= RC);
            e.pad   = (c >= RC + 2) && x;
            e.en    = (c >= RC + 2 + SC);
            e.lane  = e.en;
            e.ready = e.en;
        end else begin
            d       = c - k;
            e.pad   = (d < 2) ? ((k >= RC + 2) && x) : 1'b0;
            e.pdn   = (d >= 3);
            e.idle  = (d >= 4);
            e.err   = (f[0] && d >= 2) || (f[1] && d >= 3) || (f[2] && d >= 4);
        end
        return e;
    endfunction

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic check_obs(string ctx, obs_t a, obs_t e);
        check_bit({"R2 phy_reset ", ctx}, a.rst, e.rst);
        check_bit({"R3 ref_pad_sel ", ctx}, a.pad, e.pad);
        check_bit({"R4 phy_en ", ctx}, a.en, e.en);
        check_bit({"R4 lane_pwr ", ctx}, a.lane, e.lane);
        check_bit({"R8 pwr_down ", ctx}, a.pdn, e.pdn);
        check_bit({"R4 ready ", ctx}, a.ready, e.ready);
        check_bit({"R5 idle ", ctx}, a.idle, e.idle);
        check_bit({"R9 err ", ctx}, a.err, e.err);
    endtask

    // One full sequence from idle: start, optional noise, stop at cycle k
    task automatic run_seq(string ctx, bit x, int k, logic [2:0] f, bit noise);
        @(negedge clk);
        xtal_present = x;
        fault        = f;
        start_req    = 1'b1;
        stop_req     = 1'b0;
        for (int c = 1; c <= k + 4; c++) begin
            @(negedge clk);
            check_obs(ctx, observe(), expect_at(c, k, x, f));
            stop_req  = (c == k);
            start_req = noise && (c < k) && (($urandom % 4) == 0);
        end
        start_req = 1'b0;
        stop_req  = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        obs_t snap;
        int   k;
        void'($urandom(32'h5EED_1234));

        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_obs("R1 after reset", observe(), obs_t'(8'b0000_0010));

        // R10: stop alone in idle, then start together with stop
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        check_obs("R10 stop in idle", observe(), obs_t'(8'b0000_0010));
        start_req = 1'b1;
        stop_req  = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        stop_req  = 1'b0;
        check_obs("R10 start with stop in idle", observe(), obs_t'(8'b0000_0010));

        // Full power-up with crystal, powered dwell, then teardown (R2 R3 R4 R8)
        run_seq("xtal up/down", 1'b1, RC + SC + 6, 3'b000, 1'b0);
        // Without crystal, pad select stays low
        run_seq("no xtal up/down", 1'b0, RC + SC + 5, 3'b000, 1'b0);

        // R6: start pulse while powered must be ignored
        @(negedge clk);
        xtal_present = 1'b1;
        start_req    = 1'b1;
        repeat (RC + SC + 3) begin
            @(negedge clk);
            start_req = 1'b0;
        end
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        check_bit("R6 ready after start while powered", ready_o, 1'b1);
        check_bit("R6 reset after start while powered", phy_reset_o, 1'b0);
        check_bit("R6 idle after start while powered", idle_o, 1'b0);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        check_bit("R7 enable low after stop", phy_en_o, 1'b0);
        repeat (4) @(negedge clk);
        check_bit("R8 idle after teardown", idle_o, 1'b1);

        // R7: stop in each power-up phase
        run_seq("R7 stop in reset pulse", 1'b1, 2, 3'b000, 1'b0);
        run_seq("R7 stop at ref select", 1'b1, RC + 1, 3'b000, 1'b0);
        run_seq("R7 stop in settle", 1'b1, RC + 4, 3'b000, 1'b0);

        // R9: readback fault on each echo bit, sticky then cleared by start
        run_seq("R9 enable echo fault", 1'b1, RC + SC + 3, 3'b001, 1'b0);
        run_seq("R9 pad echo fault", 1'b1, RC + SC + 3, 3'b010, 1'b0);
        run_seq("R9 pdn echo fault", 1'b0, RC + 3, 3'b100, 1'b0);
        fault = 3'b000;
        repeat (3) @(negedge clk);
        check_bit("R9 err sticky in idle", err_o, 1'b1);
        run_seq("R9 clean run clears err", 1'b1, RC + SC + 3, 3'b000, 1'b0);

        // R1: reset in the middle of a power-up
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        repeat (RC + 3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        snap = observe();
        check_obs("R1 mid-sequence reset", snap, obs_t'(8'b0000_0010));

        // Random sequences with spurious starts
        for (int i = 0; i < 40; i++) begin
            logic [2:0] f;
            k = 1 + int'($urandom % (RC + SC + 8));
            case ($urandom % 5)
                0: f = 3'b001;
                1: f = 3'b010;
                2: f = 3'b100;
                default: f = 3'b000;
            endcase
            run_seq("random", 1'($urandom % 2), k, f, 1'b1);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule